// File: doc/BRIEF.md
# Sensorless Six-Step Commutation Sequencer

This block drives a three-phase brushless fan motor that has no rotor position sensors. Each cycle it decides which phase sources current, which phase sinks it, and which one floats. It then turns that decision into registered high-side and low-side gate enables for phases U, V and W. At power-up the motor cannot produce back-EMF, so the step advances on a free-running startup tick. Once enough consecutive zero-cross flags arrive on the floating phase, in the expected order, the block hands over to closed-loop stepping. From then on, each accepted zero-cross arms a delay of half the previous step period, and the commutation follows when that delay expires.

A speed PWM input gates the sourcing transistor. While the PWM is off, the same leg's low side conducts (synchronous rectification). A current-limit trip cuts the sourcing transistor until the next PWM rising edge. No leg ever turns on both transistors, and every hand-over between the two sides of a leg passes through one dead cycle with both off.

When PWM stays low and no valid zero-cross is seen for a programmable window, the motor is treated as stopped. The block then drops into a power-save state with every gate off, and a high PWM level wakes it back into startup. An unconnected PWM pin is expected to be pulled high at the pad, which gives full drive.

Top module: `bldc_comm_seq`

## Requirements
- R1: Steps are numbered 0 to 5, and the phase bit order is bit 0 = U, bit 1 = V, bit 2 = W. The (source, sink) pair for each step is: 0 (U,V), 1 (U,W), 2 (V,W), 3 (V,U), 4 (W,U), 5 (W,V). A commutation moves to the next step (5 wraps to 0) when `dir_i` is 1, so the source order is U, V, W. It moves to the previous step (0 wraps to 5) when `dir_i` is 0, so the source order is U, W, V. The step is 0 after reset.
- R2: Outside power-save, the source phase's high-side enable is 1 only while `pwm_i` is high and no current-limit cutoff is active. After any cycle with `pwm_i` low, no high-side enable is set.
- R3: Outside power-save, the sink phase's low side is on continuously. Whenever the source high side is held off by PWM or by a cutoff, the source low side is on instead. The floating phase has both enables off.
- R4: A cycle with `ilim_i` high switches off every high-side enable from the next cycle onward. The cutoff lasts until a rising edge of `pwm_i` that does not coincide with a new trip.
- R5: `hs_o[p]` and `ls_o[p]` are never 1 together. An enable on one side of a leg only turns on if the other side of that leg was off in the previous cycle.
- R6: In the startup state, each cycle with `start_tick_i` high performs one commutation.
- R7: A zero-cross is valid when the floating phase's bit of `zc_i` is set and no other bit is set. After `START_ZC` consecutive valid zero-crosses in startup, the block enters the run state. The last of these zero-crosses arms the commutation delay, and a startup tick in that same cycle is ignored.
- R8: In startup, a `zc_i` pattern with any non-floating bit set clears the consecutive-zero-cross count.
- R9: In run, a valid zero-cross arms a delay D = floor(P/2), where P is the number of clock edges strictly between the previous two commutations. The commutation occurs on the (D+1)th edge after the zero-cross edge.
- R10: In run, `start_tick_i` has no effect, and zero-crosses that arrive while a delay is pending are ignored.
- R11: In startup or run, after `STOP_CYC` consecutive edges with `pwm_i` low and no valid zero-cross, the block enters power-save on the following edge. In power-save all enables are off and the step is held.
- R12: In power-save, the block stays put while `pwm_i` is low. A high `pwm_i` moves it to startup with the zero-cross count cleared, and the step is kept.
- R13: While `rst_n` is low, all gate enables are 0 and the block is in power-save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Rotation direction, 1 = U,V,W source order |
| pwm_i | input | 1 | Speed PWM; high = drive on |
| start_tick_i | input | 1 | One-cycle pulse from the startup oscillator |
| zc_i | input | 3 | Back-EMF zero-cross flags per phase (bit 0 = U) |
| ilim_i | input | 1 | Current-limit trip flag |
| hs_o | output | 3 | High-side gate enables per phase |
| ls_o | output | 3 | Low-side gate enables per phase |

## Verification
A current-limit trip and the PWM rising edge that ends an earlier cutoff can fall in the same cycle. The trip must win, so the sourcing transistor stays off until the following rising edge. The bench provokes this by raising `ilim_i` on the exact cycle `pwm_i` returns high. It judges the result both through the reference model's every-cycle comparison and through a directed check that the high sides stay off several cycles later. A second coincidence is a startup tick in the same cycle as the final qualifying zero-cross. In that case the hand-over must take priority and the tick must not step the motor.

// File: rtl/bldc_seq_pkg.sv
package bldc_seq_pkg;

  localparam int unsigned NPH = 3;
  localparam logic [2:0]  LAST_STEP = 3'd5;

  typedef enum logic [1:0] {
    SQ_PSAVE = 2'd0,
    SQ_START = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_e;

  // phase index that sources current in a given step
  function automatic logic [1:0] src_phase(input logic [2:0] step);
    return step[2:1];
  endfunction

  // phase index that sinks current in a given step
  function automatic logic [1:0] snk_phase(input logic [2:0] step);
    logic [1:0] ph;
    case (step)
      3'd0:       ph = 2'd1;
      3'd1, 3'd2: ph = 2'd2;
      3'd3, 3'd4: ph = 2'd0;
      default:    ph = 2'd1;
    endcase
    return ph;
  endfunction

endpackage

// File: rtl/bldc_leg.sv
// One half-bridge: registered enables with a dead cycle on every side change.
module bldc_leg (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi_i,
  input  logic want_lo_i,
  output logic hs_o,
  output logic ls_o
);

  logic hs_d, ls_d;

  always_comb begin
    hs_d = want_hi_i & ~ls_o;
    ls_d = want_lo_i & ~hs_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
    end else begin
      hs_o <= hs_d;
      ls_o <= ls_d;
    end
  end

endmodule

// File: rtl/bldc_gate_drv.sv
// PWM gating, synchronous rectification and current-limit cutoff.
module bldc_gate_drv
  import bldc_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwm_i,
  input  logic           ilim_i,
  input  logic [NPH-1:0] src_oh_i,
  input  logic [NPH-1:0] snk_oh_i,
  output logic [NPH-1:0] hs_o,
  output logic [NPH-1:0] ls_o
);

  logic pwm_q, cut_q;
  logic pwm_rise, cut_d, drive_on;

  always_comb begin
    pwm_rise = pwm_i & ~pwm_q;
    cut_d    = ilim_i | (cut_q & ~pwm_rise);
    drive_on = pwm_i & ~cut_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      cut_q <= 1'b0;
    end else begin
      pwm_q <= pwm_i;
      cut_q <= cut_d;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    bldc_leg u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .want_hi_i (src_oh_i[p] & drive_on),
      .want_lo_i (snk_oh_i[p] | (src_oh_i[p] & ~drive_on)),
      .hs_o      (hs_o[p]),
      .ls_o      (ls_o[p])
    );
  end

endmodule

// File: rtl/bldc_phase_map.sv
// Decodes step and state into source, sink and floating phase masks.
module bldc_phase_map
  import bldc_seq_pkg::*;
(
  input  seq_state_e     st_i,
  input  logic [2:0]     step_i,
  output logic [NPH-1:0] src_oh_o,
  output logic [NPH-1:0] snk_oh_o,
  output logic [NPH-1:0] flt_oh_o
);

  logic       active;
  logic [1:0] src_ix, snk_ix;

  always_comb begin
    active = (st_i != SQ_PSAVE);
    src_ix = src_phase(step_i);
    snk_ix = snk_phase(step_i);
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    always_comb begin
      src_oh_o[p] = active && (src_ix == 2'(p));
      snk_oh_o[p] = active && (snk_ix == 2'(p));
      flt_oh_o[p] = (src_ix != 2'(p)) && (snk_ix != 2'(p));
    end
  end

endmodule

// File: rtl/bldc_step_ctrl.sv
// State machine: power-save, open-loop startup, back-EMF run.
module bldc_step_ctrl
  import bldc_seq_pkg::*;
#(
  parameter int unsigned START_ZC = 6,
  parameter int unsigned STOP_CYC = 50000,
  parameter int unsigned PER_W    = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir_i,
  input  logic           pwm_i,
  input  logic           tick_i,
  input  logic [NPH-1:0] zc_i,
  input  logic [NPH-1:0] flt_oh_i,
  output seq_state_e     st_o,
  output logic [2:0]     step_o
);

  localparam int unsigned GOOD_W = $clog2(START_ZC + 1);
  localparam int unsigned IDLE_W = $clog2(STOP_CYC + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(START_ZC - 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM  = IDLE_W'(STOP_CYC);
  localparam logic [PER_W-1:0]  PER_MAX   = '1;

  seq_state_e        st_q, st_d;
  logic [2:0]        step_q, step_d, step_adv;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [PER_W-1:0]  per_q, per_d, perq_q, perq_d, dly_q, dly_d;
  logic              dact_q, dact_d;
  logic              zc_hit, zc_bad, zc_val, stop_hit, comm;

  always_comb begin
    zc_hit   = |(zc_i & flt_oh_i);
    zc_bad   = |(zc_i & ~flt_oh_i);
    zc_val   = zc_hit & ~zc_bad;
    stop_hit = (idle_q == IDLE_LIM);
    if (dir_i) step_adv = (step_q == LAST_STEP) ? 3'd0 : step_q + 3'd1;
    else       step_adv = (step_q == 3'd0) ? LAST_STEP : step_q - 3'd1;
  end

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    good_d = good_q;
    perq_d = perq_q;
    dly_d  = dly_q;
    dact_d = dact_q;
    per_d  = (per_q == PER_MAX) ? per_q : per_q + 1'b1;
    if (pwm_i || zc_val) idle_d = '0;
    else if (stop_hit)   idle_d = idle_q;
    else                 idle_d = idle_q + 1'b1;
    comm = 1'b0;

    unique case (st_q)
      SQ_PSAVE: begin
        if (pwm_i) begin
          st_d   = SQ_START;
          good_d = '0;
          dact_d = 1'b0;
          per_d  = '0;
        end
      end
      SQ_START: begin
        if (stop_hit) begin
          st_d = SQ_PSAVE;
        end else begin
          if (zc_bad)      good_d = '0;
          else if (zc_val) good_d = good_q + 1'b1;
          if (zc_val && (good_q == GOOD_LAST)) begin
            st_d   = SQ_RUN;
            good_d = '0;
            dact_d = 1'b1;
            dly_d  = perq_q >> 1;
          end else if (tick_i) begin
            comm = 1'b1;
          end
        end
      end
      SQ_RUN: begin
        if (stop_hit) begin
          st_d = SQ_PSAVE;
        end else if (dact_q) begin
          if (dly_q == '0) begin
            comm   = 1'b1;
            dact_d = 1'b0;
          end else begin
            dly_d = dly_q - 1'b1;
          end
        end else if (zc_val) begin
          dact_d = 1'b1;
          dly_d  = perq_q >> 1;
        end
      end
      default: st_d = SQ_PSAVE;
    endcase

    if (comm) begin
      step_d = step_adv;
      perq_d = per_q;
      per_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_PSAVE;
      step_q <= 3'd0;
      good_q <= '0;
      idle_q <= '0;
      per_q  <= '0;
      perq_q <= '0;
      dly_q  <= '0;
      dact_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      good_q <= good_d;
      idle_q <= idle_d;
      per_q  <= per_d;
      perq_q <= perq_d;
      dly_q  <= dly_d;
      dact_q <= dact_d;
    end
  end

  assign st_o   = st_q;
  assign step_o = step_q;

endmodule

// File: rtl/bldc_comm_seq.sv
module bldc_comm_seq
  import bldc_seq_pkg::*;
#(
  parameter int unsigned START_ZC = 6,
  parameter int unsigned STOP_CYC = 50000,
  parameter int unsigned PER_W    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_i,
  input  logic       pwm_i,
  input  logic       start_tick_i,
  input  logic [2:0] zc_i,
  input  logic       ilim_i,
  output logic [2:0] hs_o,
  output logic [2:0] ls_o
);

  seq_state_e     st;
  logic [2:0]     step;
  logic [NPH-1:0] src_oh, snk_oh, flt_oh;

  bldc_step_ctrl #(
    .START_ZC (START_ZC),
    .STOP_CYC (STOP_CYC),
    .PER_W    (PER_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_i    (dir_i),
    .pwm_i    (pwm_i),
    .tick_i   (start_tick_i),
    .zc_i     (zc_i),
    .flt_oh_i (flt_oh),
    .st_o     (st),
    .step_o   (step)
  );

  bldc_phase_map u_map (
    .st_i     (st),
    .step_i   (step),
    .src_oh_o (src_oh),
    .snk_oh_o (snk_oh),
    .flt_oh_o (flt_oh)
  );

  bldc_gate_drv u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_i    (pwm_i),
    .ilim_i   (ilim_i),
    .src_oh_i (src_oh),
    .snk_oh_i (snk_oh),
    .hs_o     (hs_o),
    .ls_o     (ls_o)
  );

endmodule

// File: rtl/bldc_comm_seq_chk.sv
module bldc_comm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_i,
  input logic       ilim_i,
  input logic [2:0] hs_o,
  input logic [2:0] ls_o
);

  AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o & ls_o) == 3'b000);  // R5

  AST_DEAD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_o & $past(ls_o)) == 3'b000) && ((ls_o & $past(hs_o)) == 3'b000));  // R5

  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_o));  // R2

  AST_PWM_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_i |=> (hs_o == 3'b000));  // R2

  AST_TRIP_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_i |=> (hs_o == 3'b000));  // R4

  AST_LOW_SIDE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ls_o) <= 2);  // R3

endmodule

bind bldc_comm_seq bldc_comm_seq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pwm_i  (pwm_i),
  .ilim_i (ilim_i),
  .hs_o   (hs_o),
  .ls_o   (ls_o)
);

// File: tb/tb_bldc_comm_seq.sv
module tb_bldc_comm_seq;

  localparam int STOP = 40;
  localparam int NZC  = 6;
  localparam int PMAX = 65535;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir = 1'b1, pwm = 1'b0, tick = 1'b0, ilim = 1'b0;
  logic [2:0] zc = 3'b000;
  logic [2:0] hs, ls;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string cur_req = "R13";

  always #5 clk = ~clk;

  bldc_comm_seq #(.START_ZC(NZC), .STOP_CYC(STOP), .PER_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .dir_i(dir), .pwm_i(pwm), .start_tick_i(tick),
    .zc_i(zc), .ilim_i(ilim), .hs_o(hs), .ls_o(ls)
  );

  // step table from R1: source and sink phase per step
  function automatic int hi_of(input int s);
    return s / 2;
  endfunction
  function automatic int lo_of(input int s);
    case (s)
      0: return 1;
      1, 2: return 2;
      3, 4: return 0;
      default: return 1;
    endcase
  endfunction

  // behavioural reference model (state: 0 power-save, 1 startup, 2 run)
  int m_st, m_step, m_good, m_per, m_perq, m_dly, m_idle;
  bit m_dact, m_cut, m_pwmq;
  logic [2:0] m_hs, m_ls;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_step = 0; m_good = 0; m_per = 0; m_perq = 0; m_dly = 0;
      m_idle = 0; m_dact = 0; m_cut = 0; m_pwmq = 0; m_hs = 0; m_ls = 0;
    end else begin
      bit rise, cutn, on, val, bad, stop, comm;
      int src, snk, fl, n_st, n_good, n_per, n_perq, n_dly, n_idle, n_step;
      bit n_dact;
      logic [2:0] nh, nl;
      rise = pwm && !m_pwmq;
      cutn = ilim || (m_cut && !rise);
      on   = pwm && !cutn;
      src  = hi_of(m_step);
      snk  = lo_of(m_step);
      fl   = 3 - src - snk;
      for (int p = 0; p < 3; p++) begin
        bit wh, wl;
        wh = 0; wl = 0;
        if (m_st != 0) begin
          if (p == src) begin wh = on; wl = !on; end
          if (p == snk) wl = 1;
        end
        nh[p] = wh && !m_ls[p];
        nl[p] = wl && !m_hs[p];
      end
      bad  = (zc & ~(3'b001 << fl)) != 3'b000;
      val  = zc[fl] && !bad;
      stop = (m_idle == STOP);
      n_idle = (pwm || val) ? 0 : (stop ? m_idle : m_idle + 1);
      n_st = m_st; n_good = m_good; n_perq = m_perq; n_dly = m_dly;
      n_dact = m_dact; n_step = m_step; comm = 0;
      n_per = (m_per == PMAX) ? m_per : m_per + 1;
      if (m_st == 0) begin
        if (pwm) begin n_st = 1; n_good = 0; n_dact = 0; n_per = 0; end
      end else if (stop) begin
        n_st = 0;
      end else if (m_st == 1) begin
        if (bad) n_good = 0; else if (val) n_good = m_good + 1;
        if (val && m_good == NZC - 1) begin
          n_st = 2; n_good = 0; n_dact = 1; n_dly = m_perq / 2;
        end else if (tick) comm = 1;
      end else begin
        if (m_dact) begin
          if (m_dly == 0) begin comm = 1; n_dact = 0; end
          else n_dly = m_dly - 1;
        end else if (val) begin
          n_dact = 1; n_dly = m_perq / 2;
        end
      end
      if (comm) begin
        n_step = dir ? (m_step + 1) % 6 : (m_step + 5) % 6;
        n_perq = m_per; n_per = 0;
      end
      m_st = n_st; m_step = n_step; m_good = n_good; m_per = n_per;
      m_perq = n_perq; m_dly = n_dly; m_dact = n_dact; m_idle = n_idle;
      m_cut = cutn; m_pwmq = pwm; m_hs = nh; m_ls = nl;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (hs !== m_hs || ls !== m_ls) begin
        errors++;
        $display("FAIL %s model compare: hs=%b ls=%b expected hs=%b ls=%b",
                 cur_req, hs, ls, m_hs, m_ls);
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic chk_ne(input string req, input string what,
                        input logic [5:0] got, input logic [5:0] old);
    checks++;
    if (got === old) begin
      errors++;
      $display("FAIL %s %s: got %b expected a value other than %b", req, what, got, old);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic zc_good();
    @(negedge clk) zc = 3'b001 << (3 - hi_of(m_step) - lo_of(m_step));
    @(negedge clk) zc = 3'b000;
  endtask

  task automatic zc_wrong();
    @(negedge clk) zc = 3'b001 << hi_of(m_step);
    @(negedge clk) zc = 3'b000;
  endtask

  task automatic start_round();
    pulse_tick();
    cyc(8);
    zc_good();
    cyc(8);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no completion expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] saved;
    // R13: reset state
    cyc(3);
    chk("R13", "hs in reset", hs, 3'b000);
    chk("R13", "ls in reset", ls, 3'b000);
    @(negedge clk) rst_n = 1'b1;
    cur_req = "R12";
    cyc(5);
    chk("R12", "hs power-save pwm low", hs, 3'b000);
    chk("R12", "ls power-save pwm low", ls, 3'b000);
    pwm = 1'b1;
    cyc(6);
    chk("R12", "hs after wake step0", hs, 3'b001);
    chk("R12", "ls after wake step0", ls, 3'b010);

    // R1 and R6: forward then reverse order under startup ticks
    cur_req = "R1";
    dir = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      int es;
      pulse_tick();
      cyc(4);
      es = k % 6;
      chk("R1", "forward hs", hs, 3'b001 << hi_of(es));
      chk("R1", "forward ls", ls, 3'b001 << lo_of(es));
    end
    dir = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      int es;
      pulse_tick();
      cyc(4);
      es = (6 - k) % 6;
      chk("R1", "reverse hs", hs, 3'b001 << hi_of(es));
      chk("R1", "reverse ls", ls, 3'b001 << lo_of(es));
    end
    dir = 1'b1;

    // R2 / R3: PWM gating with synchronous rectification
    cur_req = "R2";
    pwm = 1'b0;
    cyc(4);
    chk("R2", "hs pwm low", hs, 3'b000);
    chk("R3", "ls pwm low", ls, 3'b011);
    pwm = 1'b1;
    cyc(4);
    chk("R2", "hs pwm high", hs, 3'b001);
    chk("R3", "ls pwm high", ls, 3'b010);
    cur_req = "R5";
    for (int k = 0; k < 10; k++) begin
      pwm = 1'b1; cyc(3);
      pwm = 1'b0; cyc(2);
    end
    pwm = 1'b1;
    cyc(4);

    // R4: current-limit cutoff and the trip-on-rise coincidence
    cur_req = "R4";
    @(negedge clk) ilim = 1'b1;
    @(negedge clk) ilim = 1'b0;
    cyc(4);
    chk("R4", "hs after trip", hs, 3'b000);
    chk("R4", "ls after trip", ls, 3'b011);
    pwm = 1'b0; cyc(2);
    pwm = 1'b1; cyc(4);
    chk("R4", "hs after pwm rise", hs, 3'b001);
    pwm = 1'b0; cyc(2);
    @(negedge clk) begin pwm = 1'b1; ilim = 1'b1; end
    @(negedge clk) ilim = 1'b0;
    cyc(4);
    chk("R4", "hs trip on rise", hs, 3'b000);
    pwm = 1'b0; cyc(2);
    pwm = 1'b1; cyc(4);
    chk("R4", "hs next rise", hs, 3'b001);

    // R8: wrong-phase zero-cross clears the count
    cur_req = "R8";
    for (int k = 0; k < 3; k++) start_round();
    zc_wrong();
    for (int k = 0; k < 2; k++) start_round();
    saved = {hs, ls};
    pulse_tick();
    cyc(4);
    chk_ne("R8", "still stepping on ticks", {hs, ls}, saved);
    zc_wrong();

    // R7: hand-over after the required run of valid zero-crosses
    cur_req = "R7";
    for (int k = 0; k < NZC; k++) start_round();
    cyc(20);

    // R10: startup tick ignored in run
    cur_req = "R10";
    saved = {hs, ls};
    pulse_tick();
    cyc(4);
    chk("R10", "hs tick ignored", hs, saved[5:3]);
    chk("R10", "ls tick ignored", ls, saved[2:0]);

    // R9: delayed commutation after zero-cross
    cur_req = "R9";
    zc_good();
    saved = {hs, ls};
    cyc(3);
    chk("R9", "hs during delay", hs, saved[5:3]);
    chk("R9", "ls during delay", ls, saved[2:0]);
    cyc(20);
    chk_ne("R9", "commutated after delay", {hs, ls}, saved);
    for (int k = 0; k < 6; k++) begin
      zc_good();
      cyc(18);
    end

    // R11: stop detection into power-save
    cur_req = "R11";
    pwm = 1'b0;
    cyc(10);
    chk_ne("R11", "still driving low sides", {3'b000, ls}, 6'b000000);
    cyc(50);
    chk("R11", "hs power-save", hs, 3'b000);
    chk("R11", "ls power-save", ls, 3'b000);

    // R12 and R6: wake and startup stepping
    cur_req = "R12";
    pwm = 1'b1;
    cyc(4);
    chk_ne("R12", "drives after wake", {hs, 3'b000}, 6'b000000);
    cur_req = "R6";
    saved = {hs, ls};
    pulse_tick();
    cyc(4);
    chk_ne("R6", "tick steps in startup", {hs, ls}, saved);
    cyc(3);
    finish_run();
  end

endmodule